// File: doc/BRIEF.md
# Shared Block Lock Arbiter with Switching Matrix

This block lets several processing units share eight memory blocks. A unit must first win a one-bit lock for a block before the switching matrix routes its reads and writes to that block. A test operation checks the lock and claims it in one step. The unit gets a granted or busy answer one cycle later. A busy unit simply tries again later. When it has finished, the owning unit releases the lock with an explicit release operation.

Each unit drives one operation per cycle on a 2-bit opcode, together with a 19-bit address. The top three address bits pick the block and the low sixteen bits give the word inside it. When several units test the same free lock in the same cycle, the lowest-numbered unit wins. Units that own different blocks reach them at the same time. Each block port carries only its owner's traffic. The memories themselves sit outside this block.

Top module: `blk_lock_xbar`

## Requirements
- R1: While reset is low and in the first cycle after it, every lock is free, and u_grant, u_busy, u_blocked and m_en are all zero.
- R2: Address bits [18:16] select the block and bits [15:0] are the word address. Only the word field is presented on m_addr of the selected block.
- R3: Opcodes are 00 idle, 01 test, 10 release and 11 access. A test on a free block claims it and answers granted. A test on a block owned by another unit answers busy and leaves the owner unchanged.
- R4: Every test gets exactly one of u_grant or u_busy in the cycle after it, for one cycle. A cycle that follows a non-test operation shows neither.
- R5: When several units test the same free block in one cycle, the lowest-numbered unit is granted and all the others see busy.
- R6: A release from the owner frees the block at the next edge. A test on that block in the same cycle as the release still sees it held and gets busy.
- R7: A release from a unit that does not own the block is ignored, and the owner keeps the block.
- R8: An access from the owner drives the block's m_en, m_we, m_addr and m_wdata in the same cycle, and returns that block's m_rdata on the unit's u_rdata.
- R9: An access from a unit that does not own the addressed block raises u_blocked in the same cycle, drives no block enable and returns zero data.
- R10: Units that own different blocks access them in the same cycle without interfering.
- R11: A test from the unit that already owns the block answers granted and leaves ownership unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_op | input | 2*N_UNITS | Opcode per unit (00 idle, 01 test, 10 release, 11 access) |
| u_addr | input | 19*N_UNITS | Per-unit address: block [18:16], word [15:0] |
| u_we | input | N_UNITS | Per-unit write enable for access |
| u_wdata | input | DATA_W*N_UNITS | Per-unit write data |
| u_grant | output | N_UNITS | Test answered granted (one cycle after test) |
| u_busy | output | N_UNITS | Test answered busy (one cycle after test) |
| u_blocked | output | N_UNITS | Access refused because the unit does not own the block |
| u_rdata | output | DATA_W*N_UNITS | Read data routed from the owned block |
| m_en | output | 8 | Per-block access enable |
| m_we | output | 8 | Per-block write enable |
| m_addr | output | 16*8 | Per-block word address |
| m_wdata | output | DATA_W*8 | Per-block write data |
| m_rdata | input | DATA_W*8 | Per-block read data from the memories |

## Verification
There are two kinds of result. The routing results (m_en, m_we, m_addr, m_wdata, u_blocked and u_rdata) follow the current operation within the same cycle. The bench therefore drives each operation at the falling edge and samples the routing outputs half a nanosecond later, before the rising edge. Test answers and changes of ownership take effect at the rising edge. The bench reads u_grant and u_busy half a nanosecond after that edge and only then advances its own lock model, so every answer is compared against the lock state that held before the edge.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam int NBLK   = 8;
  localparam int SEL_W  = 3;
  localparam int WORD_W = 16;
  localparam int ADDR_W = SEL_W + WORD_W;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_TEST = 2'b01,
    OP_FREE = 2'b10,
    OP_ACC  = 2'b11
  } op_e;

  function automatic logic [SEL_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/lock_table.sv
module lock_table
  import blk_lock_pkg::*;
#(
  parameter int N_UNITS = 4,
  localparam int IW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_UNITS-1:0][1:0]       op,
  input  logic [N_UNITS-1:0][SEL_W-1:0] blk,
  output logic [NBLK-1:0]               locked_o,
  output logic [NBLK-1:0][IW-1:0]       owner_o,
  output logic [N_UNITS-1:0]            grant_q,
  output logic [N_UNITS-1:0]            busy_q
);
  // lowest set bit of a request vector
  function automatic logic [N_UNITS-1:0] iso_lowest(input logic [N_UNITS-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IW-1:0] idx_of(input logic [N_UNITS-1:0] onehot);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N_UNITS; i++) if (onehot[i]) r = IW'(i);
    return r;
  endfunction

  logic [NBLK-1:0]               locked_q;
  logic [NBLK-1:0][IW-1:0]       owner_q;
  logic [NBLK-1:0][N_UNITS-1:0]  req, win;
  logic [NBLK-1:0]               rel_hit;
  logic [N_UNITS-1:0]            grant_d, busy_d;

  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      for (int u = 0; u < N_UNITS; u++)
        req[b][u] = (op[u] == OP_TEST) && (blk[u] == SEL_W'(b));
      win[b]     = iso_lowest(req[b]);
      rel_hit[b] = locked_q[b] && (op[owner_q[b]] == OP_FREE) &&
                   (blk[owner_q[b]] == SEL_W'(b));
    end
    for (int u = 0; u < N_UNITS; u++) begin
      logic ok;
      ok = (!locked_q[blk[u]] && win[blk[u]][u]) ||
           (locked_q[blk[u]] && owner_q[blk[u]] == IW'(u));
      grant_d[u] = (op[u] == OP_TEST) && ok;
      busy_d[u]  = (op[u] == OP_TEST) && !ok;
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        locked_q[b] <= 1'b0;
        owner_q[b]  <= '0;
      end else if (!locked_q[b] && |req[b]) begin
        locked_q[b] <= 1'b1;
        owner_q[b]  <= idx_of(win[b]);
      end else if (rel_hit[b]) begin
        locked_q[b] <= 1'b0;
      end
    end

    a_r3_held_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q[b] && !rel_hit[b]) |=> (locked_q[b] && $stable(owner_q[b])));
    a_r7_free_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q[b]) |-> $past(rel_hit[b]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      busy_q  <= '0;
    end else begin
      grant_q <= grant_d;
      busy_q  <= busy_d;
    end
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_resp_chk
    a_r4_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_q[u] && busy_q[u]));
    a_r4_answer_after_test: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q[u] || busy_q[u]) |-> ($past(op[u]) == OP_TEST));
  end

  assign locked_o = locked_q;
  assign owner_o  = owner_q;
endmodule

// File: rtl/route_matrix.sv
module route_matrix
  import blk_lock_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 32,
  localparam int IW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS-1:0][1:0]        op,
  input  logic [N_UNITS-1:0][ADDR_W-1:0] addr,
  input  logic [N_UNITS-1:0]             we,
  input  logic [N_UNITS-1:0][DATA_W-1:0] wdata,
  input  logic [NBLK-1:0]                locked,
  input  logic [NBLK-1:0][IW-1:0]        owner,
  input  logic [NBLK-1:0][DATA_W-1:0]    m_rdata,
  output logic [NBLK-1:0]                m_en,
  output logic [NBLK-1:0]                m_we,
  output logic [NBLK-1:0][WORD_W-1:0]    m_addr,
  output logic [NBLK-1:0][DATA_W-1:0]    m_wdata,
  output logic [N_UNITS-1:0][DATA_W-1:0] u_rdata,
  output logic [N_UNITS-1:0]             u_blocked
);
  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      logic hit;
      hit        = locked[b] && (op[owner[b]] == OP_ACC) &&
                   (blk_of(addr[owner[b]]) == SEL_W'(b));
      m_en[b]    = hit;
      m_we[b]    = hit && we[owner[b]];
      m_addr[b]  = hit ? word_of(addr[owner[b]]) : '0;
      m_wdata[b] = hit ? wdata[owner[b]] : '0;
    end
    for (int u = 0; u < N_UNITS; u++) begin
      logic [SEL_W-1:0] s;
      logic has, acc;
      s            = blk_of(addr[u]);
      acc          = (op[u] == OP_ACC);
      has          = locked[s] && (owner[s] == IW'(u));
      u_blocked[u] = acc && !has;
      u_rdata[u]   = (acc && has) ? m_rdata[s] : '0;
    end
  end
endmodule

// File: rtl/blk_lock_xbar.sv
module blk_lock_xbar
  import blk_lock_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 32,
  localparam int IW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*N_UNITS-1:0]        u_op,
  input  logic [ADDR_W*N_UNITS-1:0]   u_addr,
  input  logic [N_UNITS-1:0]          u_we,
  input  logic [DATA_W*N_UNITS-1:0]   u_wdata,
  output logic [N_UNITS-1:0]          u_grant,
  output logic [N_UNITS-1:0]          u_busy,
  output logic [N_UNITS-1:0]          u_blocked,
  output logic [DATA_W*N_UNITS-1:0]   u_rdata,
  output logic [NBLK-1:0]             m_en,
  output logic [NBLK-1:0]             m_we,
  output logic [WORD_W*NBLK-1:0]      m_addr,
  output logic [DATA_W*NBLK-1:0]      m_wdata,
  input  logic [DATA_W*NBLK-1:0]      m_rdata
);
  logic [N_UNITS-1:0][1:0]        op;
  logic [N_UNITS-1:0][ADDR_W-1:0] addr;
  logic [N_UNITS-1:0][SEL_W-1:0]  blk;
  logic [N_UNITS-1:0][DATA_W-1:0] wdata, rdata;
  logic [NBLK-1:0][DATA_W-1:0]    mrd, mwd;
  logic [NBLK-1:0][WORD_W-1:0]    mad;
  logic [NBLK-1:0]                locked;
  logic [NBLK-1:0][IW-1:0]        owner;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign op[u]    = u_op[2*u +: 2];
    assign addr[u]  = u_addr[ADDR_W*u +: ADDR_W];
    assign blk[u]   = blk_of(addr[u]);
    assign wdata[u] = u_wdata[DATA_W*u +: DATA_W];
    assign u_rdata[DATA_W*u +: DATA_W] = rdata[u];

    a_r9_refused_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      u_blocked[u] |-> !(m_en[blk[u]] && owner[blk[u]] == IW'(u)));
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_port
    assign mrd[b] = m_rdata[DATA_W*b +: DATA_W];
    assign m_addr[WORD_W*b +: WORD_W]  = mad[b];
    assign m_wdata[DATA_W*b +: DATA_W] = mwd[b];

    a_r8_enable_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      m_en[b] |-> locked[b]);
  end

  lock_table #(.N_UNITS(N_UNITS)) u_table (
    .clk(clk), .rst_n(rst_n), .op(op), .blk(blk),
    .locked_o(locked), .owner_o(owner),
    .grant_q(u_grant), .busy_q(u_busy)
  );

  route_matrix #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) u_route (
    .op(op), .addr(addr), .we(u_we), .wdata(wdata),
    .locked(locked), .owner(owner), .m_rdata(mrd),
    .m_en(m_en), .m_we(m_we), .m_addr(mad), .m_wdata(mwd),
    .u_rdata(rdata), .u_blocked(u_blocked)
  );
endmodule

// File: tb/blk_lock_xbar_bench.sv
`timescale 1ns/1ps
module blk_lock_xbar_bench;
  localparam int N = 4;
  localparam int DW = 32;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*N-1:0]  u_op = '0;
  logic [19*N-1:0] u_addr = '0;
  logic [N-1:0]    u_we = '0;
  logic [DW*N-1:0] u_wdata = '0;
  logic [N-1:0]    u_grant, u_busy, u_blocked;
  logic [DW*N-1:0] u_rdata;
  logic [NB-1:0]   m_en, m_we;
  logic [16*NB-1:0] m_addr;
  logic [DW*NB-1:0] m_wdata, m_rdata;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [1:0]  op_a [N];
  logic [2:0]  bk_a [N];
  logic [15:0] wd_a [N];
  logic        we_a [N];
  logic [31:0] dt_a [N];
  bit          lk [NB];
  int          ow [NB];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(int b);
    return 32'hC0DE_0000 ^ (32'(b) * 32'h1111_0101);
  endfunction

  always_comb for (int b = 0; b < NB; b++) m_rdata[DW*b +: DW] = mem_word(b);

  blk_lock_xbar #(.N_UNITS(N), .DATA_W(DW)) u_blk_lock_xbar (
    .clk(clk), .rst_n(rst_n), .u_op(u_op), .u_addr(u_addr), .u_we(u_we),
    .u_wdata(u_wdata), .u_grant(u_grant), .u_busy(u_busy),
    .u_blocked(u_blocked), .u_rdata(u_rdata), .m_en(m_en), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_idle();
    for (int u = 0; u < N; u++) begin
      op_a[u] = 2'b00; bk_a[u] = '0; wd_a[u] = '0; we_a[u] = 0; dt_a[u] = '0;
    end
  endtask

  task automatic run_cycle(string tag);
    logic [N-1:0] eg, ebz, ebl;
    logic [NB-1:0] een, ewe;
    bit claimed [NB];
    int nown [NB];
    bit nlk [NB];
    @(negedge clk);
    for (int u = 0; u < N; u++) begin
      u_op[2*u +: 2] = op_a[u];
      u_addr[19*u +: 19] = {bk_a[u], wd_a[u]};
      u_we[u] = we_a[u];
      u_wdata[DW*u +: DW] = dt_a[u];
    end
    #0.5;
    een = '0; ewe = '0;
    for (int u = 0; u < N; u++) begin
      bit has, acc;
      acc = (op_a[u] == 2'b11);
      has = lk[bk_a[u]] && ow[bk_a[u]] == u;
      ebl[u] = acc && !has;
      chk(tag, $sformatf("u%0d rdata", u), 64'(u_rdata[DW*u +: DW]),
          64'((acc && has) ? mem_word(bk_a[u]) : 32'h0));
      if (acc && has) begin
        een[bk_a[u]] = 1;
        ewe[bk_a[u]] = we_a[u];
        chk(tag, $sformatf("b%0d m_addr", bk_a[u]), 64'(m_addr[16*bk_a[u] +: 16]), 64'(wd_a[u]));
        chk(tag, $sformatf("b%0d m_wdata", bk_a[u]), 64'(m_wdata[DW*bk_a[u] +: DW]), 64'(dt_a[u]));
      end
    end
    chk(tag, "u_blocked", 64'(u_blocked), 64'(ebl));
    chk(tag, "m_en", 64'(m_en), 64'(een));
    chk(tag, "m_we", 64'(m_we), 64'(ewe));
    for (int b = 0; b < NB; b++) begin claimed[b] = 0; nlk[b] = lk[b]; nown[b] = ow[b]; end
    for (int u = 0; u < N; u++) begin
      eg[u] = 0; ebz[u] = 0;
      if (op_a[u] == 2'b01) begin
        if (lk[bk_a[u]]) begin
          eg[u] = (ow[bk_a[u]] == u); ebz[u] = !eg[u];
        end else if (!claimed[bk_a[u]]) begin
          claimed[bk_a[u]] = 1; eg[u] = 1;
          nlk[bk_a[u]] = 1; nown[bk_a[u]] = u;
        end else ebz[u] = 1;
      end
      if (op_a[u] == 2'b10 && lk[bk_a[u]] && ow[bk_a[u]] == u) nlk[bk_a[u]] = 0;
    end
    @(posedge clk);
    #0.5;
    chk(tag, "u_grant", 64'(u_grant), 64'(eg));
    chk(tag, "u_busy", 64'(u_busy), 64'(ebz));
    for (int b = 0; b < NB; b++) begin lk[b] = nlk[b]; ow[b] = nown[b]; end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin lk[b] = 0; ow[b] = 0; end
    set_idle();
    repeat (3) @(posedge clk);
    #0.5;
    chk("R1", "grant in reset", 64'(u_grant), 0);
    chk("R1", "busy in reset", 64'(u_busy), 0);
    chk("R1", "m_en in reset", 64'(m_en), 0);
    @(negedge clk); rst_n = 1;
    run_cycle("R1");

    // R3: unit 2 claims block 5, unit 1 then sees busy
    set_idle(); op_a[2] = 2'b01; bk_a[2] = 3'd5; run_cycle("R3");
    set_idle(); op_a[1] = 2'b01; bk_a[1] = 3'd5; run_cycle("R3");
    // R11: owner retests
    set_idle(); op_a[2] = 2'b01; bk_a[2] = 3'd5; run_cycle("R11");
    // R2 and R8: owner write with word field
    set_idle(); op_a[2] = 2'b11; bk_a[2] = 3'd5; wd_a[2] = 16'hBEEF;
    we_a[2] = 1; dt_a[2] = 32'h1234_5678; run_cycle("R2");
    set_idle(); op_a[2] = 2'b11; bk_a[2] = 3'd5; wd_a[2] = 16'h0001; run_cycle("R8");
    // R9: non-owner access
    set_idle(); op_a[0] = 2'b11; bk_a[0] = 3'd5; we_a[0] = 1; run_cycle("R9");
    // R7: release by non-owner ignored, then busy test
    set_idle(); op_a[3] = 2'b10; bk_a[3] = 3'd5; run_cycle("R7");
    set_idle(); op_a[3] = 2'b01; bk_a[3] = 3'd5; run_cycle("R7");
    // R6: owner release with same-cycle test -> busy, then grant
    set_idle(); op_a[2] = 2'b10; bk_a[2] = 3'd5; op_a[0] = 2'b01; bk_a[0] = 3'd5; run_cycle("R6");
    set_idle(); op_a[0] = 2'b01; bk_a[0] = 3'd5; run_cycle("R6");
    // R5: three-way contest for block 1
    set_idle();
    for (int u = 1; u < N; u++) begin op_a[u] = 2'b01; bk_a[u] = 3'd1; end
    run_cycle("R5");
    // R10: unit 0 owns 5, unit 1 owns 1; concurrent accesses
    set_idle(); op_a[0] = 2'b11; bk_a[0] = 3'd5; wd_a[0] = 16'h0AA0; dt_a[0] = 32'hA;
    we_a[0] = 1; op_a[1] = 2'b11; bk_a[1] = 3'd1; wd_a[1] = 16'h0BB0; run_cycle("R10");
    // R4: idle cycle yields no answers
    set_idle(); run_cycle("R4");

    for (int i = 0; i < 3000; i++) begin
      for (int u = 0; u < N; u++) begin
        op_a[u] = 2'($urandom % 4);
        bk_a[u] = 3'($urandom % 3);
        wd_a[u] = 16'($urandom);
        we_a[u] = 1'($urandom % 2);
        dt_a[u] = $urandom;
      end
      run_cycle("R4");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule